// File: doc/BRIEF.md
# ALU Status Flag Generator

This block derives the arithmetic condition flags that follow an 8-bit or 16-bit add, subtract or bitwise logic operation, and keeps them in a 16-bit flags register together with three control flags. The datapath hands over both operands, the result it produced and the carry out of its adder. It also supplies an operation class, a byte/word select and an update enable. The block judges the outcome and latches the six status flags on the next clock edge.

The three control flags are trap (single-step), interrupt enable and string direction. They have dedicated set and clear strobes and are never touched by arithmetic. Data-move operations, and any cycle without the update enable, leave the status flags as they were. The whole register is readable as one packed word and as individual bits.

Top module: `alu_flag_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every bit of the flags register.
- R2: The packed word places carry at bit 0, parity at bit 2, half-carry at bit 4, zero at bit 6, sign at bit 7, trap at bit 8, interrupt enable at bit 9, direction at bit 10 and overflow at bit 11. All other bits read 0, and each single-bit output equals its bit in the word.
- R3: Carry takes `add_cout` after an add (class 1). After a subtract (class 2) it takes the borrow, which is the inverse of `add_cout`, since the datapath forms a-b as a + ~b + 1. `add_cout` is the carry out of bit 7 in byte mode and out of bit 15 in word mode.
- R4: Half-carry is set when the add or subtract carries or borrows across the bit 3 to bit 4 boundary.
- R5: Parity is 1 when the low 8 result bits contain an even number of ones, zero ones included, in both byte and word mode. It is 0 when the count is odd.
- R6: Zero is 1 exactly when the result is zero at the selected width. The upper result byte is ignored in byte mode (`word_sel` = 0).
- R7: Sign copies result bit 7 in byte mode and bit 15 in word mode.
- R8: For an add, overflow is set when both operand sign bits match and the result sign differs from them. For a subtract, it is set when the operand sign bits differ and the result sign differs from the first operand's sign. Sign bits are taken at the selected width.
- R9: A logic operation (class 3) clears carry, overflow and half-carry, and computes parity, zero and sign as for arithmetic.
- R10: With class 0 (data move), or with `upd_en` low, all six status flags keep their values.
- R11: Control flags change only through `ctl_set`/`ctl_clr`, with bit 0 for trap, bit 1 for interrupt enable and bit 2 for direction. Clear wins when both strobes are high. No arithmetic or logic update changes them.
- R12: Flags sampled with `upd_en` at a clock edge become visible right after that edge, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| res | input | 16 | ALU result |
| add_cout | input | 1 | Adder carry out at the selected width |
| op_class | input | 2 | 0 move, 1 add, 2 subtract, 3 logic |
| word_sel | input | 1 | 1 = 16-bit, 0 = 8-bit |
| upd_en | input | 1 | Latch status flags this cycle |
| ctl_set | input | 3 | Set strobes {direction, interrupt, trap} |
| ctl_clr | input | 3 | Clear strobes {direction, interrupt, trap} |
| flags_word | output | 16 | Packed flags register |
| cf | output | 1 | Carry / borrow |
| pf | output | 1 | Even parity of low byte |
| af | output | 1 | Half-carry |
| zf | output | 1 | Zero |
| sf | output | 1 | Sign |
| tf | output | 1 | Trap |
| ief | output | 1 | Interrupt enable |
| df | output | 1 | Direction |
| of | output | 1 | Signed overflow |

## Verification
The bench targets byte-mode results that carry garbage in the upper byte. A design that tests zero or sign over the full 16 bits would report a nonzero or negative result there. Directed sums such as 0x7F+0x01 and 0xFFFF+0x0001, and differences such as 0x00-0x01 and 0x8000-0x0001, aim at overflow and borrow. There, a swapped overflow rule, or a carry that is not inverted for subtraction, flips the flag. Random mixes of move cycles, disabled updates and colliding set/clear strobes expose a register that updates when it should hold, and a set that overrides a clear.

// File: rtl/alu_flag_unit.sv
module alu_flag_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] res,
  input  logic         add_cout,
  input  logic [1:0]   op_class,
  input  logic         word_sel,
  input  logic         upd_en,
  input  logic [2:0]   ctl_set,
  input  logic [2:0]   ctl_clr,
  output logic [15:0]  flags_word,
  output logic         cf,
  output logic         pf,
  output logic         af,
  output logic         zf,
  output logic         sf,
  output logic         tf,
  output logic         ief,
  output logic         df,
  output logic         of
);
  localparam int HB = W / 2;
  localparam logic [1:0] C_MOVE = 2'd0;
  localparam logic [1:0] C_ADD  = 2'd1;
  localparam logic [1:0] C_SUB  = 2'd2;
  localparam logic [1:0] C_LOG  = 2'd3;

  logic         a_msb, b_msb, r_msb;
  logic [W-1:0] res_m;
  logic         arith, is_sub, load;
  logic         cf_n, af_n, of_n, zf_n, pf_n;
  logic [2:0]   ctl_q;

  assign a_msb  = word_sel ? op_a[W-1] : op_a[HB-1];
  assign b_msb  = word_sel ? op_b[W-1] : op_b[HB-1];
  assign r_msb  = word_sel ? res[W-1]  : res[HB-1];
  assign res_m  = word_sel ? res : {{(W-HB){1'b0}}, res[HB-1:0]};
  assign is_sub = (op_class == C_SUB);
  assign arith  = (op_class == C_ADD) || is_sub;
  assign load   = upd_en && (op_class != C_MOVE);

  assign zf_n = (res_m == '0);
  assign pf_n = ~^res[7:0];
  assign cf_n = arith && (add_cout ^ is_sub);
  assign af_n = arith && (op_a[4] ^ op_b[4] ^ res[4]);
  assign of_n = arith && (is_sub ? (a_msb != b_msb) : (a_msb == b_msb)) && (r_msb != a_msb);

  always_ff @(posedge clk) begin
    if (rst) begin
      {cf, pf, af, zf, sf, of} <= '0;
    end else if (load) begin
      cf <= cf_n;
      pf <= pf_n;
      af <= af_n;
      zf <= zf_n;
      sf <= r_msb;
      of <= of_n;
    end
  end

  for (genvar i = 0; i < 3; i++) begin : g_ctl
    always_ff @(posedge clk) begin
      if (rst)             ctl_q[i] <= 1'b0;
      else if (ctl_clr[i]) ctl_q[i] <= 1'b0;
      else if (ctl_set[i]) ctl_q[i] <= 1'b1;
    end
  end

  assign tf  = ctl_q[0];
  assign ief = ctl_q[1];
  assign df  = ctl_q[2];

  assign flags_word = {4'b0000, of, df, ief, tf, sf, zf, 1'b0, af, 1'b0, pf, 1'b0, cf};

  a_r1_reset_clears: assert property (@(posedge clk) rst |=> flags_word == 16'h0000);

  a_r10_hold_status: assert property (@(posedge clk) disable iff (rst)
    (!upd_en || op_class == C_MOVE) |=> $stable({cf, pf, af, zf, sf, of}));

  a_r9_logic_clears: assert property (@(posedge clk) disable iff (rst)
    (upd_en && op_class == C_LOG) |=> (!cf && !of && !af));

  a_r11_ctl_stable: assert property (@(posedge clk) disable iff (rst)
    (ctl_set == 3'b000 && ctl_clr == 3'b000) |=> $stable(flags_word[10:8]));

  a_r11_clear_wins: assert property (@(posedge clk) disable iff (rst)
    (ctl_clr == 3'b111) |=> (flags_word[10:8] == 3'b000));

  a_r5_parity: assert property (@(posedge clk) disable iff (rst)
    load |=> (pf == ~^$past(res[7:0])));

  a_r2_unused_zero: assert property (@(posedge clk) disable iff (rst)
    (flags_word[15:12] == 4'h0 && flags_word[5] == 1'b0 && flags_word[3] == 1'b0 && flags_word[1] == 1'b0));
endmodule

// File: tb/tb_alu_flag_unit.sv
module tb_alu_flag_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] op_a = '0, op_b = '0, res = '0;
  logic        add_cout = 1'b0;
  logic [1:0]  op_class = 2'd0;
  logic        word_sel = 1'b0;
  logic        upd_en = 1'b0;
  logic [2:0]  ctl_set = '0, ctl_clr = '0;
  logic [15:0] flags_word;
  logic        cf, pf, af, zf, sf, tf, ief, df, of;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] exp_w = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_flag_unit dut (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .res(res),
    .add_cout(add_cout), .op_class(op_class), .word_sel(word_sel),
    .upd_en(upd_en), .ctl_set(ctl_set), .ctl_clr(ctl_clr),
    .flags_word(flags_word), .cf(cf), .pf(pf), .af(af), .zf(zf),
    .sf(sf), .tf(tf), .ief(ief), .df(df), .of(of)
  );

  function automatic logic [15:0] model(input logic [15:0] prev, a, b, r,
      input logic co, input logic [1:0] cls, input logic ws, en,
      input logic [2:0] s, c);
    logic [15:0] w;
    logic am, bm, rm, c_, p_, h_, z_, o_;
    w = prev;
    if (en && cls != 2'd0) begin
      am = ws ? a[15] : a[7];
      bm = ws ? b[15] : b[7];
      rm = ws ? r[15] : r[7];
      z_ = ws ? (r == 16'h0) : (r[7:0] == 8'h0);
      p_ = ~^r[7:0];
      c_ = 1'b0; h_ = 1'b0; o_ = 1'b0;
      if (cls == 2'd1) begin
        c_ = co; h_ = a[4] ^ b[4] ^ r[4];
        o_ = (am == bm) && (rm != am);
      end else if (cls == 2'd2) begin
        c_ = ~co; h_ = a[4] ^ b[4] ^ r[4];
        o_ = (am != bm) && (rm != am);
      end
      w[0] = c_; w[2] = p_; w[4] = h_; w[6] = z_; w[7] = rm; w[11] = o_;
    end
    for (int i = 0; i < 3; i++) begin
      if (c[i]) w[8+i] = 1'b0;
      else if (s[i]) w[8+i] = 1'b1;
    end
    return w;
  endfunction

  task automatic check(input string req);
    logic [15:0] ind;
    n_chk++;
    if (flags_word !== exp_w) begin
      n_fail++;
      $display("FAIL %s flags_word actual=%h expected=%h", req, flags_word, exp_w);
    end
    ind = {4'b0, of, df, ief, tf, sf, zf, 1'b0, af, 1'b0, pf, 1'b0, cf};
    n_chk++;
    if (ind !== exp_w) begin
      n_fail++;
      $display("FAIL R2 bit outputs actual=%h expected=%h", ind, exp_w);
    end
  endtask

  // drive one operation; computes result and carry from the operands
  task automatic op(input logic [15:0] a, b, input logic [1:0] cls, input logic ws,
                    input logic en, input logic [2:0] s, c, input logic [7:0] junk,
                    input string req);
    logic [16:0] t;
    logic [15:0] r;
    logic co;
    @(negedge clk);
    co = 1'b0;
    if (ws) begin
      case (cls)
        2'd1: t = {1'b0, a} + {1'b0, b};
        2'd2: t = {1'b0, a} + {1'b0, ~b} + 17'd1;
        2'd3: t = {1'b0, a ^ b};
        default: t = {1'b0, b};
      endcase
      r = t[15:0]; co = t[16];
    end else begin
      case (cls)
        2'd1: t = {9'b0, a[7:0]} + {9'b0, b[7:0]};
        2'd2: t = {9'b0, a[7:0]} + {9'b0, ~b[7:0]} + 17'd1;
        2'd3: t = {9'b0, a[7:0] | b[7:0]};
        default: t = {9'b0, b[7:0]};
      endcase
      r = {junk, t[7:0]}; co = t[8];
    end
    if (cls == 2'd3 || cls == 2'd0) co = junk[0];
    op_a = a; op_b = b; res = r; add_cout = co; op_class = cls;
    word_sel = ws; upd_en = en; ctl_set = s; ctl_clr = c;
    exp_w = model(exp_w, a, b, r, co, cls, ws, en, s, c);
    @(negedge clk);
    upd_en = 1'b0; ctl_set = '0; ctl_clr = '0;
    check(req);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    exp_w = 16'h0000;
    check("R1 reset state");

    // R7 R8 R4: byte 0x7F+0x01 -> 0x80, OF, AF, SF, upper junk ignored (R6)
    op(16'h007F, 16'h0001, 2'd1, 1'b0, 1'b1, 3'b000, 3'b000, 8'hA5, "R8 R4 R7 byte add overflow");
    // R3 R6 R5: word 0xFFFF+1 -> 0, CF, ZF, PF
    op(16'hFFFF, 16'h0001, 2'd1, 1'b1, 1'b1, 3'b000, 3'b000, 8'h00, "R3 R6 R5 word add wrap");
    // R3 borrow: byte 0-1
    op(16'h0000, 16'h0001, 2'd2, 1'b0, 1'b1, 3'b000, 3'b000, 8'h3C, "R3 R4 byte sub borrow");
    // R8 sub overflow word 0x8000-1
    op(16'h8000, 16'h0001, 2'd2, 1'b1, 1'b1, 3'b000, 3'b000, 8'h00, "R8 word sub overflow");
    // R6 byte zero with nonzero upper byte
    op(16'h1230, 16'h45D0, 2'd1, 1'b0, 1'b1, 3'b000, 3'b000, 8'hFF, "R6 byte zero upper ignored");
    // R9 logic clears after carry set
    op(16'hFFFF, 16'h0001, 2'd1, 1'b1, 1'b1, 3'b000, 3'b000, 8'h00, "R3 setup");
    op(16'h0F0F, 16'h00F0, 2'd3, 1'b1, 1'b1, 3'b000, 3'b000, 8'h00, "R9 logic clears CF OF AF");
    // R10 move and disabled update hold
    op(16'h0000, 16'h0000, 2'd0, 1'b1, 1'b1, 3'b000, 3'b000, 8'h11, "R10 move holds");
    op(16'h7FFF, 16'h0001, 2'd1, 1'b1, 1'b0, 3'b000, 3'b000, 8'h00, "R10 upd_en low holds");
    // R11 control strobes
    op(16'h0000, 16'h0000, 2'd0, 1'b0, 1'b0, 3'b111, 3'b000, 8'h00, "R11 set all control");
    op(16'hFFFF, 16'hFFFF, 2'd1, 1'b1, 1'b1, 3'b000, 3'b000, 8'h00, "R11 arithmetic keeps control");
    op(16'h0000, 16'h0000, 2'd0, 1'b0, 1'b0, 3'b101, 3'b111, 8'h00, "R11 clear wins");
    op(16'h0000, 16'h0000, 2'd0, 1'b0, 1'b0, 3'b010, 3'b000, 8'h00, "R11 set interrupt only");
    // R12 latency: change inputs, output shows it after the edge only
    op(16'h0001, 16'h0001, 2'd1, 1'b1, 1'b1, 3'b000, 3'b000, 8'h00, "R12 one-cycle update");

    for (int k = 0; k < 3000; k++) begin
      logic [31:0] rv;
      rv = $urandom;
      op(16'($urandom), 16'($urandom), rv[1:0], rv[2], (rv[5:3] != 3'd0),
         (rv[9:6] == 4'd0) ? rv[12:10] : 3'b000,
         (rv[16:13] == 4'd0) ? rv[19:17] : 3'b000, rv[27:20],
         "R3 R4 R5 R6 R7 R8 R9 R10 R11 random");
    end

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    exp_w = 16'h0000;
    check("R1 reset after activity");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule